// File: doc/BRIEF.md
# Interrupt Pending Mask Aggregator

This block gathers the status flags and enable bits of the on-chip peripherals (asynchronous serial port, synchronous serial port, two timer flag/mask register pairs) and seven discrete request lines. It turns them into one registered 32-bit pending mask with one bit per interrupt source, in a fixed index order. A peripheral source is pending only while both its flag and its enable are set. The four serial flag/enable pairs all feed the single serial source line, so any one active pair is enough to set that bit. Discrete requests have no enable and pass straight through.

From the registered mask the block picks the highest-index pending source with combinational logic. It reports that index, an any-pending indication, and the address of the vector word to fetch. The vector table base moves with a mode input: one base serves special bootstrap mode and another serves every other mode. Each source owns a two-byte slot above the base. The CPU core reads the index and the vector address and applies its own condition-code masking. All pins are plain level signals with no handshake: the mask is sampled every cycle and no data is transferred.

Top module: `irq_pend_agg`

## Requirements
- R1: While rst_n is low the pending mask is all zero, pend_any is 0 and pend_idx is 0. Reset is asynchronous and active low.
- R2: Mask bits 0 to 10 are reserved and always read 0.
- R3: Mask bit 12 (synchronous serial) is set exactly when spi_flag and spi_en were both 1 at the previous rising clock edge. Every mask bit is re-evaluated from its inputs on every clock edge.
- R4: Mask bit 11 (serial) is the OR of sci_flag[k] AND sci_en[k] over k = 0..3 (transmit empty, transmit complete, receive full, idle line). One active pair sets the bit even when the other pairs are inactive.
- R5: Timer register 1 holds output compares 1 to 5 in tmr1 bits 0 to 4 and input captures 1 to 3 in tmr1 bits 5 to 7. Output compare k maps to mask bit 21-k. Input capture k maps to mask bit 24-k. Each is set only when its tmr1_flag and tmr1_en bits are both 1.
- R6: In timer register 2, tmr2 bit 0 (timer overflow) maps to mask bit 15, bit 1 (real-time) to mask bit 24, bit 2 (pulse-accumulator edge) to mask bit 13, and bit 3 (pulse-accumulator overflow) to mask bit 14. Each is gated by its tmr2_en bit.
- R7: sys_req bits 0 to 6 (external, non-maskable, software, illegal opcode, watchdog, clock fail, reset) map to mask bits 25 to 31. They have no enable and are gated only by the request itself.
- R8: pend_any is 1 exactly when the mask is non-zero.
- R9: pend_idx is the highest set mask index, or 0 when nothing is pending. It changes in the same cycle as the mask.
- R10: vec_addr equals the base plus two times pend_idx. The base is BASE_BOOT (0xBFC0) when boot_mode is 1 and BASE_NORM (0xFFC0) otherwise. The reset request therefore fetches from base + 0x3E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_mode | input | 1 | 1 selects the special bootstrap vector base |
| sci_flag | input | 4 | Serial status flags (tx empty, tx complete, rx full, idle) |
| sci_en | input | 4 | Matching serial enables |
| spi_flag | input | 1 | Synchronous serial transfer-done flag |
| spi_en | input | 1 | Synchronous serial interrupt enable |
| tmr1_flag | input | 8 | Timer flag register 1 (OC1..OC5, IC1..IC3) |
| tmr1_en | input | 8 | Timer mask register 1 |
| tmr2_flag | input | 4 | Timer flag register 2 (overflow, real-time, PA edge, PA overflow) |
| tmr2_en | input | 4 | Timer mask register 2 |
| sys_req | input | 7 | Discrete requests for sources 25..31 |
| pend_mask | output | 32 | Registered pending mask |
| pend_any | output | 1 | Some source is pending |
| pend_idx | output | 5 | Highest pending index |
| vec_addr | output | 16 | Vector fetch address |

## Verification
The serial line is the main target. The bench drives one pair with its flag set and enable cleared next to another pair that is fully active. A design that let an inactive pair clear the shared bit would drop the serial interrupt. The reversed index order of the output-compare and input-capture bits is checked one bit at a time, because a straight mapping would send capture 1 to bit 21 and not bit 23. Vector checks cover both bases with the reset request active (0xBFFE and 0xFFFE) and the empty mask, where a design that shifted the wrong way or ignored the mode would fetch from the wrong table. Random patterns with sparse discrete requests move the winner across the whole index range, and a reset asserted mid-stream must empty the mask at once.

// File: rtl/irq_pend_pkg.sv
`timescale 1ns/1ps
package irq_pend_pkg;
  localparam int NUM_SRC  = 32;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int NUM_RSV  = 11;
  localparam int NUM_SCI  = 4;
  localparam int NUM_OC   = 5;
  localparam int NUM_IC   = 3;
  localparam int T1_W     = NUM_OC + NUM_IC;
  localparam int T2_W     = 4;
  localparam int NUM_SYS  = 7;

  localparam int SRC_SCI     = 11;
  localparam int SRC_SPI     = 12;
  localparam int SRC_PA_EDGE = 13;
  localparam int SRC_PA_OVF  = 14;
  localparam int SRC_TOF     = 15;
  localparam int SRC_OC_TOP  = 21;  // output compare k lands on 21-k
  localparam int SRC_IC_TOP  = 24;  // input capture k lands on 24-k
  localparam int SRC_RTI     = 24;
  localparam int SRC_SYS0    = 25;

  localparam int T2_TOF  = 0;
  localparam int T2_RTI  = 1;
  localparam int T2_PAE  = 2;
  localparam int T2_PAO  = 3;

  typedef logic [NUM_SRC-1:0] src_mask_t;
  typedef logic [IDX_W-1:0]   src_idx_t;
endpackage

// File: rtl/irq_pair_gate.sv
`timescale 1ns/1ps
module irq_pair_gate #(
  parameter int N = 4
) (
  input  logic [N-1:0] flag,
  input  logic [N-1:0] en,
  output logic [N-1:0] hit
);
  for (genvar g = 0; g < N; g++) begin : g_pair
    assign hit[g] = flag[g] & en[g];
  end
endmodule

// File: rtl/irq_src_map.sv
`timescale 1ns/1ps
module irq_src_map
  import irq_pend_pkg::*;
(
  input  logic [NUM_SCI-1:0] sci_hit,
  input  logic               spi_hit,
  input  logic [T1_W-1:0]    t1_hit,
  input  logic [T2_W-1:0]    t2_hit,
  input  logic [NUM_SYS-1:0] sys_hit,
  output src_mask_t          raw_mask
);
  // reserved low indices
  for (genvar r = 0; r < NUM_RSV; r++) begin : g_rsv
    assign raw_mask[r] = 1'b0;
  end

  // shared serial line: any active pair raises it
  assign raw_mask[SRC_SCI]     = |sci_hit;
  assign raw_mask[SRC_SPI]     = spi_hit;
  assign raw_mask[SRC_PA_EDGE] = t2_hit[T2_PAE];
  assign raw_mask[SRC_PA_OVF]  = t2_hit[T2_PAO];
  assign raw_mask[SRC_TOF]     = t2_hit[T2_TOF];
  assign raw_mask[SRC_RTI]     = t2_hit[T2_RTI];

  for (genvar k = 1; k <= NUM_OC; k++) begin : g_oc
    assign raw_mask[SRC_OC_TOP-k] = t1_hit[k-1];
  end

  for (genvar k = 1; k <= NUM_IC; k++) begin : g_ic
    assign raw_mask[SRC_IC_TOP-k] = t1_hit[NUM_OC+k-1];
  end

  for (genvar j = 0; j < NUM_SYS; j++) begin : g_sys
    assign raw_mask[SRC_SYS0+j] = sys_hit[j];
  end
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick
  import irq_pend_pkg::*;
(
  input  src_mask_t mask,
  output logic      any,
  output src_idx_t  idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (mask[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_gen.sv
`timescale 1ns/1ps
module irq_vec_gen
  import irq_pend_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_NORM = 16'hFFC0,
  parameter logic [ADDR_W-1:0] BASE_BOOT = 16'hBFC0
) (
  input  logic              boot_mode,
  input  src_idx_t          idx,
  output logic [ADDR_W-1:0] vec_addr
);
  localparam int SLOT_SH = 1;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offs;

  assign base     = boot_mode ? BASE_BOOT : BASE_NORM;
  assign offs     = ADDR_W'(idx) << SLOT_SH;
  assign vec_addr = base + offs;
endmodule

// File: rtl/irq_pend_agg.sv
`timescale 1ns/1ps
module irq_pend_agg
  import irq_pend_pkg::*;
#(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_NORM = 16'hFFC0,
  parameter logic [ADDR_W-1:0] BASE_BOOT = 16'hBFC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_mode,
  input  logic [3:0]        sci_flag,
  input  logic [3:0]        sci_en,
  input  logic              spi_flag,
  input  logic              spi_en,
  input  logic [7:0]        tmr1_flag,
  input  logic [7:0]        tmr1_en,
  input  logic [3:0]        tmr2_flag,
  input  logic [3:0]        tmr2_en,
  input  logic [6:0]        sys_req,
  output logic [31:0]       pend_mask,
  output logic              pend_any,
  output logic [4:0]        pend_idx,
  output logic [ADDR_W-1:0] vec_addr
);
  logic [NUM_SCI-1:0] sci_hit;
  logic [0:0]         spi_hit;
  logic [T1_W-1:0]    t1_hit;
  logic [T2_W-1:0]    t2_hit;
  logic [NUM_SYS-1:0] sys_hit;
  src_mask_t          raw_mask;
  src_mask_t          mask_q;
  src_idx_t           idx_w;

  irq_pair_gate #(.N(NUM_SCI)) u_sci (.flag(sci_flag),  .en(sci_en),  .hit(sci_hit));
  irq_pair_gate #(.N(1))       u_spi (.flag(spi_flag),  .en(spi_en),  .hit(spi_hit));
  irq_pair_gate #(.N(T1_W))    u_t1  (.flag(tmr1_flag), .en(tmr1_en), .hit(t1_hit));
  irq_pair_gate #(.N(T2_W))    u_t2  (.flag(tmr2_flag), .en(tmr2_en), .hit(t2_hit));
  // discrete requests have no enable register: tie enables high
  irq_pair_gate #(.N(NUM_SYS)) u_sys (.flag(sys_req), .en({NUM_SYS{1'b1}}), .hit(sys_hit));

  irq_src_map u_map (
    .sci_hit (sci_hit),
    .spi_hit (spi_hit[0]),
    .t1_hit  (t1_hit),
    .t2_hit  (t2_hit),
    .sys_hit (sys_hit),
    .raw_mask(raw_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= raw_mask;
  end

  irq_prio_pick u_pick (.mask(mask_q), .any(pend_any), .idx(idx_w));

  irq_vec_gen #(
    .ADDR_W   (ADDR_W),
    .BASE_NORM(BASE_NORM),
    .BASE_BOOT(BASE_BOOT)
  ) u_vec (
    .boot_mode(boot_mode),
    .idx      (idx_w),
    .vec_addr (vec_addr)
  );

  assign pend_mask = mask_q;
  assign pend_idx  = idx_w;
endmodule

// File: rtl/irq_pend_agg_chk.sv
`timescale 1ns/1ps
module irq_pend_agg_chk #(
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_NORM = 16'hFFC0,
  parameter logic [ADDR_W-1:0] BASE_BOOT = 16'hBFC0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boot_mode,
  input logic [3:0]        sci_flag,
  input logic [3:0]        sci_en,
  input logic              spi_flag,
  input logic              spi_en,
  input logic [7:0]        tmr1_flag,
  input logic [7:0]        tmr1_en,
  input logic [6:0]        sys_req,
  input logic [31:0]       pend_mask,
  input logic              pend_any,
  input logic [4:0]        pend_idx,
  input logic [ADDR_W-1:0] vec_addr
);
  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rst_n |=> (pend_mask == '0)); // R1

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pend_mask[10:0] == '0); // R2

  AST_SPI_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> pend_mask[12] == $past(spi_flag & spi_en)); // R3

  AST_SCI_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> pend_mask[11] == $past(|(sci_flag & sci_en))); // R4

  AST_IC1_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> pend_mask[23] == $past(tmr1_flag[5] & tmr1_en[5])); // R5

  AST_XIRQ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> pend_mask[26] == $past(sys_req[1])); // R7

  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_any |-> (pend_mask == '0 && pend_idx == '0)); // R8

  AST_TOP_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |-> ((pend_mask >> pend_idx) == 32'd1)); // R9

  AST_VEC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr == ((boot_mode ? BASE_BOOT : BASE_NORM) + {pend_idx, 1'b0})); // R10
endmodule

bind irq_pend_agg irq_pend_agg_chk #(
  .ADDR_W   (ADDR_W),
  .BASE_NORM(BASE_NORM),
  .BASE_BOOT(BASE_BOOT)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .boot_mode(boot_mode),
  .sci_flag (sci_flag),
  .sci_en   (sci_en),
  .spi_flag (spi_flag),
  .spi_en   (spi_en),
  .tmr1_flag(tmr1_flag),
  .tmr1_en  (tmr1_en),
  .sys_req  (sys_req),
  .pend_mask(pend_mask),
  .pend_any (pend_any),
  .pend_idx (pend_idx),
  .vec_addr (vec_addr)
);

// File: tb/irq_pend_agg_tb_top.sv
`timescale 1ns/1ps
module irq_pend_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_mode = 1'b0;
  logic [3:0]  sci_flag = '0, sci_en = '0;
  logic        spi_flag = 1'b0, spi_en = 1'b0;
  logic [7:0]  tmr1_flag = '0, tmr1_en = '0;
  logic [3:0]  tmr2_flag = '0, tmr2_en = '0;
  logic [6:0]  sys_req = '0;
  logic [31:0] pend_mask;
  logic        pend_any;
  logic [4:0]  pend_idx;
  logic [15:0] vec_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_pend_agg dut_i (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
    .sci_flag(sci_flag), .sci_en(sci_en),
    .spi_flag(spi_flag), .spi_en(spi_en),
    .tmr1_flag(tmr1_flag), .tmr1_en(tmr1_en),
    .tmr2_flag(tmr2_flag), .tmr2_en(tmr2_en),
    .sys_req(sys_req),
    .pend_mask(pend_mask), .pend_any(pend_any),
    .pend_idx(pend_idx), .vec_addr(vec_addr)
  );

  function automatic logic [31:0] model_mask();
    logic [31:0] m = '0;
    m[11] = |(sci_flag & sci_en);
    m[12] = spi_flag & spi_en;
    for (int k = 1; k <= 5; k++) m[21-k] = tmr1_flag[k-1] & tmr1_en[k-1];
    for (int k = 1; k <= 3; k++) m[24-k] = tmr1_flag[4+k] & tmr1_en[4+k];
    m[15] = tmr2_flag[0] & tmr2_en[0];
    m[24] = tmr2_flag[1] & tmr2_en[1];
    m[13] = tmr2_flag[2] & tmr2_en[2];
    m[14] = tmr2_flag[3] & tmr2_en[3];
    for (int j = 0; j < 7; j++) m[25+j] = sys_req[j];
    return m;
  endfunction

  function automatic logic [4:0] model_top(input logic [31:0] m);
    logic [4:0] r = '0;
    for (int i = 0; i < 32; i++) if (m[i]) r = 5'(i);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge, with the inputs that the last rising edge captured still applied
  task automatic check_all();
    logic [31:0] em = model_mask();
    logic [4:0]  ei = model_top(em);
    logic [15:0] ev = (boot_mode ? 16'hBFC0 : 16'hFFC0) + {10'd0, ei, 1'b0};
    chk(pend_mask[10:0] == 11'd0, "R2", {21'd0, pend_mask[10:0]}, 32'd0);
    chk(pend_mask[12] == em[12], "R3", {31'd0, pend_mask[12]}, {31'd0, em[12]});
    chk(pend_mask[11] == em[11], "R4", {31'd0, pend_mask[11]}, {31'd0, em[11]});
    chk(pend_mask[23:16] == em[23:16], "R5", {24'd0, pend_mask[23:16]}, {24'd0, em[23:16]});
    chk({pend_mask[24], pend_mask[15:13]} == {em[24], em[15:13]}, "R6",
        {28'd0, pend_mask[24], pend_mask[15:13]}, {28'd0, em[24], em[15:13]});
    chk(pend_mask[31:25] == em[31:25], "R7", {25'd0, pend_mask[31:25]}, {25'd0, em[31:25]});
    chk(pend_any == (em != 0), "R8", {31'd0, pend_any}, {31'd0, em != 0});
    chk(pend_idx == ei, "R9", {27'd0, pend_idx}, {27'd0, ei});
    chk(vec_addr == ev, "R10", {16'd0, vec_addr}, {16'd0, ev});
  endtask

  task automatic apply(input logic b, input logic [3:0] sf, input logic [3:0] se,
                       input logic pf, input logic pe, input logic [7:0] f1, input logic [7:0] e1,
                       input logic [3:0] f2, input logic [3:0] e2, input logic [6:0] rq);
    boot_mode = b; sci_flag = sf; sci_en = se; spi_flag = pf; spi_en = pe;
    tmr1_flag = f1; tmr1_en = e1; tmr2_flag = f2; tmr2_en = e2; sys_req = rq;
    @(negedge clk);
    check_all();
  endtask

  task automatic expect_vec(input logic [15:0] ev, input string req);
    chk(vec_addr == ev, req, {16'd0, vec_addr}, {16'd0, ev});
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    // R1: inputs active while reset is held
    sci_flag = 4'hF; sci_en = 4'hF; sys_req = 7'h7F;
    repeat (3) @(negedge clk);
    chk(pend_mask == 32'd0, "R1", pend_mask, 32'd0);
    chk(!pend_any && pend_idx == 5'd0, "R1", {26'd0, pend_any, pend_idx}, 32'd0);
    rst_n = 1'b1;

    // R4: single pair, flags without enables, one active pair beside an inactive one
    apply(0, 4'b0001, 4'b0001, 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 7'h00);
    expect_vec(16'hFFD6, "R4");
    apply(0, 4'b1111, 4'b0000, 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 7'h00);
    apply(0, 4'b0011, 4'b0010, 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 7'h00);
    chk(pend_mask[11], "R4", pend_mask, 32'h800);
    for (int k = 0; k < 4; k++)
      apply(0, 4'(1 << k), 4'(1 << k), 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 7'h00);
    // R3
    apply(0, 4'h0, 4'h0, 1, 0, 8'h00, 8'h00, 4'h0, 4'h0, 7'h00);
    apply(0, 4'h0, 4'h0, 1, 1, 8'h00, 8'h00, 4'h0, 4'h0, 7'h00);
    // R5: each timer-1 bit on its own
    for (int b = 0; b < 8; b++)
      apply(0, 4'h0, 4'h0, 0, 0, 8'(1 << b), 8'hFF, 4'h0, 4'h0, 7'h00);
    apply(0, 4'h0, 4'h0, 0, 0, 8'h01, 8'h01, 4'h0, 4'h0, 7'h00);
    chk(pend_mask == 32'h0010_0000, "R5", pend_mask, 32'h0010_0000);
    apply(0, 4'h0, 4'h0, 0, 0, 8'h20, 8'h20, 4'h0, 4'h0, 7'h00);
    chk(pend_mask == 32'h0080_0000, "R5", pend_mask, 32'h0080_0000);
    // R6
    for (int b = 0; b < 4; b++)
      apply(0, 4'h0, 4'h0, 0, 0, 8'h00, 8'h00, 4'(1 << b), 4'hF, 7'h00);
    // R7 / R10 both bases with reset request
    apply(1, 4'h0, 4'h0, 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 7'h40);
    expect_vec(16'hBFFE, "R10");
    apply(0, 4'h0, 4'h0, 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 7'h40);
    expect_vec(16'hFFFE, "R10");
    for (int j = 0; j < 7; j++)
      apply(0, 4'h0, 4'h0, 0, 0, 8'h00, 8'h00, 4'h0, 4'h0, 7'(1 << j));
    // R9: everything on, then nothing
    apply(1, 4'hF, 4'hF, 1, 1, 8'hFF, 8'hFF, 4'hF, 4'hF, 7'h7F);
    chk(pend_idx == 5'd31, "R9", {27'd0, pend_idx}, 32'd31);
    apply(1, 4'h0, 4'hF, 0, 1, 8'h00, 8'hFF, 4'h0, 4'hF, 7'h00);
    chk(!pend_any, "R8", {31'd0, pend_any}, 32'd0);
    expect_vec(16'hBFC0, "R10");

    // random traffic, sparse discrete requests
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] rq;
      rq = '0;
      for (int j = 0; j < 7; j++) rq[j] = ($urandom % 12) == 0;
      apply(1'($urandom), 4'($urandom) & 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
            8'($urandom) & 8'($urandom), 8'($urandom), 4'($urandom), 4'($urandom), rq);
      if (n == 1500) begin
        // R1: reset asserted mid-stream empties the mask at once
        rst_n = 1'b0;
        #1;
        chk(pend_mask == 32'd0 && !pend_any, "R1", pend_mask, 32'd0);
        @(negedge clk);
        chk(pend_mask == 32'd0, "R1", pend_mask, 32'd0);
        rst_n = 1'b1;
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule